// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the divider settings of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output-divide code and a 2-bit test selector. Software or board straps can supply them in two ways. The first way uses wide parallel inputs together with an active-low load strobe. While the strobe is low the registers follow the inputs. When the strobe rises they hold their value. The second way uses a serial path: a serial clock shifts a 14-bit frame into a shift register, and a serial load strobe copies the frame into the active registers.

The strobes, the serial clock and the serial data all arrive without a relation to the system clock. They pass through a bank of synchronizers, and the serial clock and serial load are edge-detected in the system clock domain. A test output is chosen by the test selector. It can be held low, or it can show the last bit of the shift register, a feedback-divider signal or a copy of the synthesized clock. It is forced low whenever parallel mode is active.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset the divide value is 10, the output-divide code is 0, the test selector is 0 and the test output is low.
- R2: While the parallel load strobe is low, the divide value and the output-divide code follow the parallel inputs within 3 system clocks.
- R3: After the parallel load strobe rises, later changes on the parallel inputs leave the divide value and the output-divide code unchanged.
- R4: With the parallel strobe high, each serial clock rise shifts the serial data bit into the shift register at bit 0. The first bit shifted ends at bit 13. The frame order, first bit first, is: test selector bit 1, test selector bit 0, one discarded slot, output-divide code bit 1, code bit 0, then divide value bit 8 down to bit 0.
- R5: A rise of the serial load strobe, with the parallel strobe high, copies the frame into the registers. Bits 13:12 go to the test selector, bits 10:9 to the output-divide code and bits 8:0 to the divide value. The discarded slot (bit 11) has no effect.
- R6: Once the serial load strobe is low again, further serial shifting leaves the registers unchanged.
- R7: While the serial load strobe stays high, each serial clock rise updates all three registers from the shift register contents as they are after that shift.
- R8: In serial mode the test selector picks the test output: 0 gives low, 1 gives shift register bit 13, 2 gives the feedback-divider input, 3 gives the synthesized-clock input.
- R9: The test output is low whenever the parallel load strobe is low, whatever the test selector holds.
- R10: Serial clock edges while the parallel strobe is low leave the shift register unchanged.
- R11: While the parallel strobe is low, a serial load rise has no effect. The registers keep following the parallel inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| par_load_n | input | 1 | Parallel load strobe, active low (registers transparent while low) |
| par_m | input | 9 | Parallel divide value |
| par_n | input | 2 | Parallel output-divide code |
| ser_clk | input | 1 | Serial shift clock (asynchronous, sampled) |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe |
| mdiv_in | input | 1 | Feedback-divider signal that the test output can show |
| fout_in | input | 1 | Synthesized-clock copy that the test output can show |
| m_val | output | 9 | Active divide value |
| n_code | output | 2 | Active output-divide code |
| t_sel | output | 2 | Active test selector |
| test_out | output | 1 | Test output |

## Verification
Every asynchronous input goes through two synchronizer flops. An edge-detect term then feeds a register, so a register update appears at the third rising system-clock edge after the input changes. The test output is combinational from those registers and from the two signal inputs. The bench drives every input on a falling edge and then waits four falling edges before it samples. It also sets the serial data one cycle before it raises the serial clock, so the data bit and the clock pass through their synchronizers in step. The bench keeps its own copy of the shift register and derives every expected field from that copy by division and remainder.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int NULL_W  = 1;
  localparam int FRAME_W = T_W + NULL_W + N_W + M_W;
  localparam int LO_W    = N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'd0,
    TSEL_SHIFT = 2'd1,
    TSEL_MDIV  = 2'd2,
    TSEL_FOUT  = 2'd3
  } tsel_e;

  // Build a configuration from the frame's top field and its low fields.
  function automatic cfg_t frame_fields(input logic [T_W-1:0] top,
                                        input logic [LO_W-1:0] low);
    cfg_t c;
    c.t = top;
    c.n = low[LO_W-1:M_W];
    c.m = low[M_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int W       = 4,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/edge_det.sv
module edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= lvl;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_rise
      assign rise[g] = lvl[g] & ~dly_q[g];
    end
  endgenerate
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import synth_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_evt,
  input  logic               sd,
  output logic [FRAME_W-1:0] shreg_q,
  output logic [FRAME_W-1:0] shnext
);
  assign shnext = {shreg_q[FRAME_W-2:0], sd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg_q <= '0;
    else if (shift_evt) shreg_q <= shnext;
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int M_RESET = 10,
  parameter int N_RESET = 0,
  parameter int T_RESET = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     par_mode,
  input  cfg_t     par_cfg,
  input  logic     xfer_evt,
  input  cfg_t     xfer_cfg,
  input  logic     pass_evt,
  input  cfg_t     pass_cfg,
  output cfg_t     cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.m <= M_W'(M_RESET);
      cfg_q.n <= N_W'(N_RESET);
      cfg_q.t <= T_W'(T_RESET);
    end else if (par_mode) begin
      cfg_q.m <= par_cfg.m;
      cfg_q.n <= par_cfg.n;
    end else if (xfer_evt) begin
      cfg_q <= xfer_cfg;
    end else if (pass_evt) begin
      cfg_q <= pass_cfg;
    end
  end
endmodule

// File: rtl/test_mux.sv
module test_mux
  import synth_cfg_pkg::*;
(
  input  logic [T_W-1:0] sel,
  input  logic           par_mode,
  input  logic           ser_out,
  input  logic           mdiv_in,
  input  logic           fout_in,
  output logic           test_out
);
  logic picked;

  always_comb begin
    unique case (tsel_e'(sel))
      TSEL_LOW:   picked = 1'b0;
      TSEL_SHIFT: picked = ser_out;
      TSEL_MDIV:  picked = mdiv_in;
      TSEL_FOUT:  picked = fout_in;
      default:    picked = 1'b0;
    endcase
  end

  assign test_out = picked & ~par_mode;
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_RESET     = 10,
  parameter int N_RESET     = 0,
  parameter int T_RESET     = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           mdiv_in,
  input  logic           fout_in,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] t_sel,
  output logic           test_out
);
  localparam int NSYNC = 4;
  localparam int NEDGE = 2;

  // Synchronized levels: {data, serial load, serial clock, parallel strobe}
  logic [NSYNC-1:0] sync_lvl;
  logic [NEDGE-1:0] edge_rise;
  logic pl_lvl, sc_lvl, sl_lvl, sd_lvl;
  logic sc_rise, sl_rise;

  sync_bank #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ser_data, ser_load, ser_clk, par_load_n}),
    .lvl(sync_lvl)
  );

  assign {sd_lvl, sl_lvl, sc_lvl, pl_lvl} = sync_lvl;

  edge_det #(.W(NEDGE)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({sl_lvl, sc_lvl}),
    .rise(edge_rise)
  );

  assign {sl_rise, sc_rise} = edge_rise;

  // Named internal events
  logic par_mode, shift_evt, xfer_evt, pass_evt;
  assign par_mode  = ~pl_lvl;
  assign shift_evt = pl_lvl & sc_rise;
  assign xfer_evt  = pl_lvl & sl_rise;
  assign pass_evt  = pl_lvl & sl_lvl & sc_rise & ~sl_rise;

  logic [FRAME_W-1:0] shreg_q, shnext;

  cfg_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_evt(shift_evt), .sd(sd_lvl),
    .shreg_q(shreg_q), .shnext(shnext)
  );

  cfg_t par_cfg, xfer_cfg, pass_cfg, cfg_q;
  assign par_cfg  = '{t: '0, n: par_n, m: par_m};
  assign xfer_cfg = frame_fields(shreg_q[FRAME_W-1 -: T_W], shreg_q[LO_W-1:0]);
  assign pass_cfg = frame_fields(shnext[FRAME_W-1 -: T_W], shnext[LO_W-1:0]);

  cfg_regs #(.M_RESET(M_RESET), .N_RESET(N_RESET), .T_RESET(T_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .par_mode(par_mode), .par_cfg(par_cfg),
    .xfer_evt(xfer_evt), .xfer_cfg(xfer_cfg),
    .pass_evt(pass_evt), .pass_cfg(pass_cfg),
    .cfg_q(cfg_q)
  );

  assign m_val  = cfg_q.m;
  assign n_code = cfg_q.n;
  assign t_sel  = cfg_q.t;

  test_mux u_tmux (
    .sel(cfg_q.t), .par_mode(par_mode),
    .ser_out(shreg_q[FRAME_W-1]),
    .mdiv_in(mdiv_in), .fout_in(fout_in),
    .test_out(test_out)
  );
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
  import synth_cfg_pkg::*;
#(
  parameter int M_RESET = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               par_mode,
  input logic               shift_evt,
  input logic               xfer_evt,
  input logic               pass_evt,
  input logic               sd,
  input logic [FRAME_W-1:0] shreg,
  input logic [M_W-1:0]     par_m,
  input logic [N_W-1:0]     par_n,
  input logic [M_W-1:0]     m_val,
  input logic [N_W-1:0]     n_code,
  input logic [T_W-1:0]     t_sel,
  input logic               test_out
);
  // R1
  a_r1_reset_defaults: assert property (@(posedge clk)
    !rst_n |=> (m_val == M_W'(M_RESET) && n_code == '0 && t_sel == '0));

  // R2
  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> (m_val == $past(par_m) && n_code == $past(par_n)));

  // R3, R6
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !xfer_evt && !pass_evt) |=>
      ($stable(m_val) && $stable(n_code) && $stable(t_sel)));

  // R4
  a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (shreg[0] == $past(sd) && shreg[FRAME_W-1:1] == $past(shreg[FRAME_W-2:0])));

  // R5
  a_r5_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> (m_val == $past(shreg[M_W-1:0]) &&
                  t_sel == $past(shreg[FRAME_W-1:FRAME_W-T_W])));

  // R7
  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    pass_evt |=> (m_val[0] == $past(sd) && m_val[M_W-1:1] == $past(shreg[M_W-2:0])));

  // R10
  a_r10_no_shift_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> $stable(shreg));

  // R9
  a_r9_test_low: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> !test_out);
endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(.M_RESET(M_RESET)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .par_mode(par_mode), .shift_evt(shift_evt), .xfer_evt(xfer_evt), .pass_evt(pass_evt),
  .sd(sd_lvl), .shreg(shreg_q),
  .par_m(par_m), .par_n(par_n),
  .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .test_out(test_out)
);

// File: tb/synth_cfg_loader_tb_top.sv
module synth_cfg_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_load_n = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic mdiv_in = 1'b0, fout_in = 1'b0;
  logic [8:0] m_val;
  logic [1:0] n_code, t_sel;
  logic test_out;

  always #5 clk = ~clk;

  synth_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .mdiv_in(mdiv_in), .fout_in(fout_in),
    .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .test_out(test_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int sh = 0;          // bench copy of the 14-bit shift register
  int exp_m = 10, exp_n = 0, exp_t = 0;
  bit plv = 1, slv = 0;

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_test();
    if (!plv) return 0;
    case (exp_t)
      0: return 0;
      1: return (sh / 8192) % 2;
      2: return int'(mdiv_in);
      default: return int'(fout_in);
    endcase
  endfunction

  task automatic take_frame();
    exp_m = sh % 512;
    exp_n = (sh / 512) % 4;
    exp_t = (sh / 4096) % 4;
  endtask

  task automatic check_all(input string tag);
    check({tag, " m"}, int'(m_val), exp_m);
    check({tag, " n"}, int'(n_code), exp_n);
    check({tag, " t"}, int'(t_sel), exp_t);
    check({tag, " test"}, int'(test_out), exp_test());
  endtask

  task automatic set_pl(input bit v);
    @(negedge clk);
    par_load_n = v; plv = v;
    if (!v) begin exp_m = int'(par_m); exp_n = int'(par_n); end
    wait_n(4);
  endtask

  task automatic set_par(input int m, input int n);
    @(negedge clk);
    par_m = 9'(m); par_n = 2'(n);
    if (!plv) begin exp_m = m; exp_n = n; end
    wait_n(4);
  endtask

  task automatic ser_bit(input bit b);
    @(negedge clk);
    ser_data = b;
    wait_n(1);
    ser_clk = 1'b1;
    if (plv) sh = (sh * 2 + int'(b)) % 16384;
    if (plv && slv) take_frame();
    wait_n(4);
    ser_clk = 1'b0;
    wait_n(4);
  endtask

  task automatic send_frame(input int f);
    for (int i = 13; i >= 0; i--) ser_bit(f[i]);
  endtask

  task automatic sload(input bit v);
    @(negedge clk);
    ser_load = v;
    if (v && plv) take_frame();
    slv = v;
    wait_n(4);
  endtask

  function automatic int mk_frame(input int t, input int nul, input int n, input int m);
    return t * 4096 + nul * 2048 + n * 512 + m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1: defaults after reset
    check_all("R1 reset");

    // R2, R9: sweep every divide value in transparent parallel mode
    set_pl(0);
    for (int v = 0; v < 512; v++) begin
      set_par(v, v % 4);
      check("R2 m follows", int'(m_val), v);
      check("R2 n follows", int'(n_code), v % 4);
      if (v % 64 == 0) check("R9 test low parallel", int'(test_out), 0);
    end

    // R3: latch on strobe rise, later inputs ignored
    set_par(421, 2);
    set_pl(1);
    set_par(60, 1);
    check_all("R3 latched");

    // R4, R5, R8: all selector/code pairs, discarded slot set to 1
    for (int k = 0; k < 16; k++) begin
      send_frame(mk_frame(k / 4, 1, k % 4, (k * 37 + 5) % 512));
      sload(1);
      check_all("R5 transfer");
      sload(0);
      check("R4 frame m", int'(m_val), (k * 37 + 5) % 512);
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        mdiv_in = s[0]; fout_in = s[1];
        wait_n(1);
        check("R8 test mux", int'(test_out), exp_test());
      end
    end

    // R6: selector 1 shows bit 13 while further shifts leave registers alone
    send_frame(mk_frame(1, 0, 3, 300));
    sload(1); sload(0);
    for (int i = 0; i < 6; i++) begin
      ser_bit(i % 2 == 0);
      check_all("R6 hold after load");
    end

    // R7: pass-through while serial load held high
    sload(1);
    for (int i = 13; i >= 0; i--) begin
      ser_bit(mk_frame(2, 1, 1, 155) >> i & 1);
      check_all("R7 pass-through");
    end
    sload(0);
    check("R7 final m", int'(m_val), 155);

    // R10: shifting while parallel strobe low is ignored
    send_frame(mk_frame(0, 0, 2, 77));
    set_par(200, 3);
    set_pl(0);
    send_frame(mk_frame(3, 1, 1, 511));
    check_all("R10 parallel during shift");
    // R11: serial load rise while parallel low has no effect
    sload(1);
    check_all("R11 load ignored");
    sload(0);
    set_pl(1);
    sload(1);
    check_all("R10 old frame kept");
    check("R10 frame m", int'(m_val), 77);
    sload(0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule